// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This controller connects a simple synchronous request port (address, write flag, write data, valid/ready handshake) to the strobe-driven pins of an asynchronous DRAM. Each request address is divided into a row part (upper bits) and a column part (lower bits). Both parts share one multiplexed address bus. The controller drives the active-low row strobe, column strobe and write strobe in the order the memory expects. All DRAM timings are whole controller clock cycles, and each is set by a parameter.

The row is left open once an access finishes. A later request to the same row runs only a column cycle. A request to any other row first closes the open row by holding the row strobe high for a full precharge period, and then opens the new row. A free-running interval counter schedules refresh. A refresh closes any open row, runs a cycle in which the column strobe falls before the row strobe, and leaves no row open. Each read returns its data with a one-cycle valid pulse. Each write finishes with a one-cycle acknowledge.

Top module: `pm_dram_ctrl`

## Requirements
- R1: During and directly after reset, the row, column and write strobes are high. The request port is ready, no response or acknowledge pulse is present, and no row is open.
- R2: A row opens in two steps. The row part sits on the address bus for one cycle with the row strobe high. The row strobe then falls and stays low for T_RCD cycles. Next, the column part sits on the bus for one cycle with the column strobe high. The column strobe then falls. The address bus is stable across each strobe's falling edge.
- R3: In a normal access the column strobe stays low for exactly T_CAS cycles. Read data is captured in the last of those cycles. For a write, the write strobe is low and the write data is driven and held steady for the whole time the column strobe is low.
- R4: A request to the open row is a page hit. It causes no new row strobe fall, and its response arrives T_CAS+1 cycles after the accepting clock edge.
- R5: A request that arrives while no row is open has its response T_RCD+T_CAS+2 cycles after acceptance.
- R6: A request to a different row than the open one first holds the row strobe high for at least T_RP cycles. Its response comes T_RP+T_RCD+T_CAS+2 cycles after acceptance. The row strobe never falls after fewer than T_RP high cycles.
- R7: Refresh starts every REF_INT cycles. The column strobe falls while the row strobe is high, and the row strobe falls in the next cycle. Afterwards no row is open, so the next request takes the R5 latency. When the controller is idle, successive refreshes start exactly REF_INT cycles apart. With the default parameters, refresh uses under 1% of cycles.
- R8: A pending refresh takes priority over requests. While it is pending, ready is low. A request held at that time is served only after the refresh, and it reopens its row.
- R9: A read response is a single-cycle rsp_valid carrying the word written most recently to that address. A write completion is a single-cycle wr_ack. The two never occur together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Upper ROW_W bits are the row, lower COL_W bits the column |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read data |
| wr_ack | output | 1 | One-cycle write completion |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_out | output | DATA_W | Data driven toward the memory |
| dram_dq_oe | output | 1 | Enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The bench counts clock edges from the edge that accepts a request to the edge after which rsp_valid or wr_ack is first visible. It compares that count with the expected latency for the case: T_CAS+1 for a page hit, T_RCD+T_CAS+2 from no open row, and T_RP+T_RCD+T_CAS+2 for a row change. One cycle later it checks that the pulse has gone. Refresh spacing is measured between the cycles in which a behavioural memory model sees the column strobe fall with the row strobe high. The priority case uses an ordering check rather than a fixed latency: the bench waits until ready drops while idle, and then confirms that a refresh and a fresh row opening both happen before the response.

// File: rtl/pm_dram_ctrl.sv
module pm_dram_ctrl #(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 3,
  parameter int T_REF_RAS = 3,
  parameter int REF_INT   = 1560
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   wr_ack,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TMAX  = (T_RCD > T_CAS ? T_RCD : T_CAS) > (T_RP > T_REF_RAS ? T_RP : T_REF_RAS)
                       ? (T_RCD > T_CAS ? T_RCD : T_CAS) : (T_RP > T_REF_RAS ? T_RP : T_REF_RAS);
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int REF_W = $clog2(REF_INT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN, S_RSET, S_ACT, S_CSET, S_CAS, S_PRE, S_RFC, S_RFR, S_RFP
  } state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic              row_vld;
  logic              have_req;
  logic [REF_W-1:0]  ref_cnt;
  logic              ref_pend;

  wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];
  wire             accept  = req_valid && req_ready;
  wire             cnt_end = (cnt == '0);
  wire             wr_phase = we_q && (st == S_CSET || st == S_CAS);

  assign req_ready   = !ref_pend && (st == S_IDLE || st == S_OPEN);
  assign dram_ras_n  = !(st inside {S_OPEN, S_ACT, S_CSET, S_CAS, S_RFR});
  assign dram_cas_n  = !(st inside {S_CAS, S_RFC, S_RFR});
  assign dram_we_n   = !wr_phase;
  assign dram_dq_oe  = wr_phase;
  assign dram_dq_out = wd_q;
  assign dram_addr   = (st == S_RSET || st == S_ACT) ? AW'(row_q) : AW'(col_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      row_q     <= '0;
      col_q     <= '0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      row_vld   <= 1'b0;
      have_req  <= 1'b0;
      ref_cnt   <= '0;
      ref_pend  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      wr_ack    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      wr_ack    <= 1'b0;
      if (accept) begin
        row_q    <= req_row;
        col_q    <= req_col;
        we_q     <= req_we;
        wd_q     <= req_wdata;
        have_req <= 1'b1;
      end
      case (st)
        S_IDLE:
          if (ref_pend) st <= S_RFC;
          else if (accept) st <= S_RSET;
        S_OPEN:
          if (ref_pend) begin
            st <= S_PRE; cnt <= CNT_W'(T_RP - 1); row_vld <= 1'b0;
          end else if (accept) begin
            if (row_vld && req_row == row_q) st <= S_CSET;
            else begin
              st <= S_PRE; cnt <= CNT_W'(T_RP - 1); row_vld <= 1'b0;
            end
          end
        S_RSET: begin st <= S_ACT; cnt <= CNT_W'(T_RCD - 1); end
        S_ACT:
          if (cnt_end) begin st <= S_CSET; row_vld <= 1'b1; end
          else cnt <= cnt - 1'b1;
        S_CSET: begin st <= S_CAS; cnt <= CNT_W'(T_CAS - 1); end
        S_CAS:
          if (cnt_end) begin
            st       <= S_OPEN;
            have_req <= 1'b0;
            if (we_q) wr_ack <= 1'b1;
            else begin rsp_valid <= 1'b1; rsp_rdata <= dram_dq_in; end
          end else cnt <= cnt - 1'b1;
        S_PRE:
          if (cnt_end) begin
            if (ref_pend) st <= S_RFC;
            else if (have_req) st <= S_RSET;
            else st <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        S_RFC: begin st <= S_RFR; cnt <= CNT_W'(T_REF_RAS - 1); ref_pend <= 1'b0; end
        S_RFR:
          if (cnt_end) begin st <= S_RFP; cnt <= CNT_W'(T_RP - 1); end
          else cnt <= cnt - 1'b1;
        S_RFP:
          if (cnt_end) st <= have_req ? S_RSET : S_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
      if (ref_cnt == REF_W'(REF_INT - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pm_dram_ctrl_chk.sv
module pm_dram_ctrl_chk #(
  parameter int AW     = 9,
  parameter int DATA_W = 16,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     addr,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              rsp_valid,
  input logic              wr_ack
);
  localparam int HI_W = $clog2(T_RP + 1) + 1;
  localparam int LO_W = $clog2(T_CAS + 2) + 1;

  logic [HI_W-1:0] ras_hi_cnt;
  logic [LO_W-1:0] cas_lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_hi_cnt <= HI_W'(T_RP);
      cas_lo_cnt <= '0;
    end else begin
      if (!ras_n) ras_hi_cnt <= '0;
      else if (ras_hi_cnt < HI_W'(T_RP)) ras_hi_cnt <= ras_hi_cnt + 1'b1;
      if (cas_n) cas_lo_cnt <= '0;
      else if (cas_lo_cnt <= LO_W'(T_CAS)) cas_lo_cnt <= cas_lo_cnt + 1'b1;
    end
  end

  assert_row_addr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(addr));
  assert_col_addr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> $stable(addr));
  assert_cas_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_n) && !ras_n) |-> (cas_lo_cnt == LO_W'(T_CAS)));
  assert_wdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !$past(cas_n)) |-> ($stable(we_n) && $stable(dq_out)));
  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ras_hi_cnt >= HI_W'(T_RP)));
  assert_cbr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |=> (!ras_n && !cas_n));
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || wr_ack) |=> !(rsp_valid || wr_ack));
  assert_one_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && wr_ack));
endmodule

bind pm_dram_ctrl pm_dram_ctrl_chk #(
  .AW(AW), .DATA_W(DATA_W), .T_CAS(T_CAS), .T_RP(T_RP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(dram_addr), .ras_n(dram_ras_n),
  .cas_n(dram_cas_n), .we_n(dram_we_n), .dq_out(dram_dq_out),
  .rsp_valid(rsp_valid), .wr_ack(wr_ack)
);

// File: tb/pm_dram_ctrl_tb_top.sv
module pm_dram_ctrl_tb_top;
  localparam int RW = 4, CW = 4, DW = 16;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, REF_INT = 400;
  localparam int LAT_HIT  = T_CAS + 1;
  localparam int LAT_IDLE = T_RCD + T_CAS + 2;
  localparam int LAT_MISS = T_RP + T_RCD + T_CAS + 2;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [7:0]  lat;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 8'h12, 16'hA001, 8'(LAT_IDLE)},
    '{1'b1, 8'h15, 16'hA002, 8'(LAT_HIT)},
    '{1'b0, 8'h12, 16'hA001, 8'(LAT_HIT)},
    '{1'b0, 8'h15, 16'hA002, 8'(LAT_HIT)},
    '{1'b1, 8'h37, 16'hB003, 8'(LAT_MISS)},
    '{1'b0, 8'h12, 16'hA001, 8'(LAT_MISS)},
    '{1'b0, 8'h37, 16'hB003, 8'(LAT_MISS)},
    '{1'b1, 8'h3F, 16'hC004, 8'(LAT_HIT)},
    '{1'b0, 8'h3F, 16'hC004, 8'(LAT_HIT)},
    '{1'b1, 8'hF0, 16'hD005, 8'(LAT_MISS)},
    '{1'b0, 8'hF0, 16'hD005, 8'(LAT_HIT)},
    '{1'b0, 8'h00, 16'h5000, 8'(LAT_MISS)}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [7:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, wr_ack;
  logic [DW-1:0] rsp_rdata;
  logic [3:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DW-1:0] dram_dq_out, dram_dq_in;

  always #4 clk = ~clk;

  pm_dram_ctrl #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
                 .T_RP(T_RP), .T_REF_RAS(3), .REF_INT(REF_INT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_ack(wr_ack),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  logic [DW-1:0] mem [256];
  logic [3:0] mrow = '0;
  logic ras_q = 1'b1, cas_q = 1'b1;
  int cyc = 0, row_opens = 0, cbr_n = 0, cbr_at = 0;
  int total = 0, fails = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h5000 + 16'(i);

  assign dram_dq_in = mem[{mrow, dram_addr}];

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    ras_q <= dram_ras_n;
    cas_q <= dram_cas_n;
    if (ras_q && !dram_ras_n && dram_cas_n) begin
      mrow <= dram_addr;
      row_opens <= row_opens + 1;
    end
    if (cas_q && !dram_cas_n && dram_ras_n) begin
      cbr_n  <= cbr_n + 1;
      cbr_at <= cyc;
    end
    if (cas_q && !dram_cas_n && !dram_ras_n && !dram_we_n && dram_dq_oe)
      mem[{mrow, dram_addr}] <= dram_dq_out;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [7:0] a, input logic [15:0] wd,
                      output int lat, output logic [15:0] rd, output logic ack);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    while (!req_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0;
    while (!(rsp_valid || wr_ack) && lat < 100) begin @(posedge clk); #1; lat++; end
    rd = rsp_rdata; ack = wr_ack;
    @(posedge clk); #1;
    check("R9 single-cycle pulse", int'(rsp_valid || wr_ack), 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int lat, opens0, c0;
    logic [15:0] rd;
    logic ack;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 ras_n", int'(dram_ras_n), 1);
    check("R1 cas_n", int'(dram_cas_n), 1);
    check("R1 we_n", int'(dram_we_n), 1);
    check("R1 outputs idle", int'(rsp_valid || wr_ack), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 ready after reset", int'(req_ready), 1);

    foreach (VECS[i]) begin
      opens0 = row_opens;
      xfer(VECS[i].we, VECS[i].addr, VECS[i].data, lat, rd, ack);
      check($sformatf("R4/R5/R6 latency vec%0d", i), lat, int'(VECS[i].lat));
      check($sformatf("R9 kind vec%0d", i), int'(ack), int'(VECS[i].we));
      if (!VECS[i].we) check($sformatf("R3/R9 read data vec%0d", i), int'(rd), int'(VECS[i].data));
      if (VECS[i].lat == 8'(LAT_HIT))
        check($sformatf("R4 no row open on hit vec%0d", i), row_opens - opens0, 0);
      else
        check($sformatf("R2 row latched vec%0d", i), int'(mrow), int'(VECS[i].addr[7:4]));
    end
    check("R3 write stored", int'(mem[8'h37]), 16'hB003);

    // R8 refresh priority with row 0 open
    while (req_ready) begin @(posedge clk); #1; end
    c0 = cbr_n; opens0 = row_opens;
    check("R8 ready low while refresh pending", int'(req_ready), 0);
    xfer(1'b0, 8'h03, 16'h0, lat, rd, ack);
    check("R8 refresh ran before request", cbr_n - c0, 1);
    check("R8 row reopened after refresh", row_opens - opens0, 1);
    check("R8 read data", int'(rd), 16'h5003);

    // R7 spacing of idle refreshes, then closed row after refresh
    c0 = cbr_n;
    while (cbr_n == c0) @(posedge clk);
    while (cbr_n == c0 + 1) @(posedge clk);
    opens0 = cbr_at;
    while (cbr_n == c0 + 2) @(posedge clk);
    check("R7 refresh interval", cbr_at - opens0, REF_INT);
    #1;
    xfer(1'b0, 8'h03, 16'h0, lat, rd, ack);
    check("R7 row closed after refresh", lat, LAT_IDLE);

    // R1 mid-run reset clears open row
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 ras_n high in reset", int'(dram_ras_n), 1);
    rst_n = 1'b1;
    xfer(1'b0, 8'h03, 16'h0, lat, rd, ack);
    check("R1 no open row after reset", lat, LAT_IDLE);
    check("R9 data after reset", int'(rd), 16'h5003);
    summary();
  end
endmodule